// File: doc/BRIEF.md
# I2C Write-Mode Command/Data Byte Parser

This block sits behind a byte-level I2C slave receiver and handles only write traffic. It takes bytes the receiver has already deserialized, together with single-cycle START and STOP indications. The first byte after START is checked against the block's 7-bit address. After that, control bytes and payload bytes are told apart. Each control byte picks where the payload goes: the command port or the display-data port. It also picks whether the payload is a single byte followed by another control byte, or an open-ended stream that ends only at STOP.

Bytes enter on a valid/ready stream. `in_ready` is high whenever the single output slot is empty, and a byte is taken on any cycle with `in_valid && in_ready`. A payload byte is presented on `out_byte` with either `cmd_valid` or `data_valid`. It stays there, unchanged, until the consumer raises `out_ready`. While a payload byte is waiting, `in_ready` is low and the upstream receiver must hold its byte, for example by stretching the clock. Each byte taken while the parser is addressed gives a one-cycle `ack_stb`, and `ack_ok` says whether the receiver should drive ACK or NACK.

Top module: `i2cw_byte_parser`

## Requirements
- R1: An address byte is matched when bits 7..1 equal {5'b01111, ADDR_LO} and bit 0 (R/W) is 0. A matched address byte is acknowledged with ack_ok=1, and the next byte is read as a control byte.
- R2: An address byte that does not match, including one with bit 0 set, gives ack_stb with ack_ok=0. After it, every byte is taken with no acknowledge strobe and no output until the next START.
- R3: Every byte taken in the address, control or payload phase raises ack_stb exactly one cycle after the byte is taken. ack_ok is 1 for control and payload bytes. In the idle phase, bytes are taken with no ack_stb.
- R4: In a control byte, bit 7 is the continue flag, bit 6 is the target (1 = display data, 0 = command), and bits 5..0 have no effect.
- R5: If the continue flag is 1, exactly one payload byte follows, and the byte after that payload is read as a control byte.
- R6: If the continue flag is 0, every later byte is a payload byte for the selected target until STOP or START.
- R7: A payload byte appears on out_byte one cycle after it is taken, with data_valid (target 1) or cmd_valid (target 0), never both. The byte and its flag stay unchanged until the cycle in which out_ready is high.
- R8: in_ready is low while a payload byte waits in the output slot. No byte is taken while in_ready is low.
- R9: START sends the parser to the address phase from any phase, and STOP sends it to idle. If both come in the same cycle, START wins. A byte offered in the same cycle as either event is taken but discarded, with no ack_stb.
- R10: After reset the parser is idle, in_ready is 1, and cmd_valid, data_valid and ack_stb are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_evt | input | 1 | One-cycle START or repeated START indication |
| stop_evt | input | 1 | One-cycle STOP indication |
| in_valid | input | 1 | Received byte is offered |
| in_ready | output | 1 | Parser can take a byte |
| in_byte | input | 8 | Received byte |
| out_byte | output | 8 | Payload byte |
| cmd_valid | output | 1 | out_byte holds a command byte |
| data_valid | output | 1 | out_byte holds a display-data byte |
| out_ready | input | 1 | Consumer takes the payload byte this cycle |
| ack_stb | output | 1 | One-cycle acknowledge decision strobe |
| ack_ok | output | 1 | 1 = ACK, 0 = NACK (meaningful with ack_stb) |

## Verification
The assertions assume that START and STOP are one-cycle pulses, and that the upstream side holds in_byte steady while in_valid waits on in_ready. The bench offers each byte only at a negative edge where in_ready is already high, and keeps it there for exactly one cycle. Event pulses are one cycle wide and are driven away from the clock edge. out_ready follows several duty patterns, so the held-output and back-pressure paths are exercised while the reference model tracks the expected acceptance cycles on its own.

// File: rtl/i2cw_pkg.sv
package i2cw_pkg;
  localparam int BYTE_W = 8;
  localparam int ADDR_HI_W = 5;
  localparam logic [ADDR_HI_W-1:0] ADDR_HI = 5'b01111;

  typedef enum logic [2:0] {
    PH_IDLE   = 3'd0,
    PH_ADDR   = 3'd1,
    PH_CTRL   = 3'd2,
    PH_PAIR   = 3'd3,
    PH_STREAM = 3'd4
  } phase_t;

  typedef struct packed {
    logic cont;
    logic to_data;
  } ctrl_t;
endpackage

// File: rtl/i2cw_addr_check.sv
module i2cw_addr_check
  import i2cw_pkg::*;
#(
  parameter logic [1:0] ADDR_LO = 2'b00
) (
  input  logic [BYTE_W-1:0] byte_in,
  output logic              match
);
  localparam int ADDR_W = ADDR_HI_W + 2;
  localparam logic [ADDR_W-1:0] OWN_ADDR = {ADDR_HI, ADDR_LO};

  always_comb begin
    match = (byte_in[BYTE_W-1:1] == OWN_ADDR) && (byte_in[0] == 1'b0);
  end
endmodule

// File: rtl/i2cw_phase_fsm.sv
module i2cw_phase_fsm
  import i2cw_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_evt,
  input  logic              stop_evt,
  input  logic              byte_take,
  input  logic [BYTE_W-1:0] byte_in,
  input  logic              addr_hit,
  output logic              ack_fire,
  output logic              ack_good,
  output logic              pay_fire,
  output logic              pay_to_data
);
  phase_t phase;
  ctrl_t  ctrl_q;
  ctrl_t  ctrl_d;
  logic   evt;
  logic   take;

  assign evt    = start_evt | stop_evt;
  assign take   = byte_take & ~evt;
  assign ctrl_d = '{cont: byte_in[7], to_data: byte_in[6]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase  <= PH_IDLE;
      ctrl_q <= '0;
    end else if (start_evt) begin
      phase <= PH_ADDR;
    end else if (stop_evt) begin
      phase <= PH_IDLE;
    end else if (take) begin
      unique case (phase)
        PH_IDLE:   phase <= PH_IDLE;
        PH_ADDR:   phase <= addr_hit ? PH_CTRL : PH_IDLE;
        PH_CTRL: begin
          ctrl_q <= ctrl_d;
          phase  <= ctrl_d.cont ? PH_PAIR : PH_STREAM;
        end
        PH_PAIR:   phase <= PH_CTRL;
        PH_STREAM: phase <= PH_STREAM;
        default:   phase <= PH_IDLE;
      endcase
    end
  end

  always_comb begin
    ack_fire    = take && (phase != PH_IDLE);
    ack_good    = (phase != PH_ADDR) || addr_hit;
    pay_fire    = take && ((phase == PH_PAIR) || (phase == PH_STREAM));
    pay_to_data = ctrl_q.to_data;
  end

  assert_nack_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_ADDR && take && !addr_hit) |=> (phase == PH_IDLE));
  assert_pair_back_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_PAIR && take) |=> (phase == PH_CTRL));
  assert_stream_stays_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_STREAM && !evt) |=> (phase == PH_STREAM));
  assert_start_addr_R9: assert property (@(posedge clk) disable iff (!rst_n)
    start_evt |=> (phase == PH_ADDR));
endmodule

// File: rtl/i2cw_out_slot.sv
module i2cw_out_slot
  import i2cw_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [BYTE_W-1:0] load_byte,
  input  logic              load_to_data,
  input  logic              out_ready,
  output logic              pend,
  output logic [BYTE_W-1:0] out_byte,
  output logic              is_data
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend     <= 1'b0;
      out_byte <= '0;
      is_data  <= 1'b0;
    end else if (load) begin
      pend     <= 1'b1;
      out_byte <= load_byte;
      is_data  <= load_to_data;
    end else if (pend && out_ready) begin
      pend <= 1'b0;
    end
  end

  assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (pend && !out_ready) |=> (pend && $stable(out_byte) && $stable(is_data)));
endmodule

// File: rtl/i2cw_byte_parser.sv
module i2cw_byte_parser
  import i2cw_pkg::*;
#(
  parameter logic [1:0] ADDR_LO = 2'b00
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_evt,
  input  logic              stop_evt,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [BYTE_W-1:0] in_byte,
  output logic [BYTE_W-1:0] out_byte,
  output logic              cmd_valid,
  output logic              data_valid,
  input  logic              out_ready,
  output logic              ack_stb,
  output logic              ack_ok
);
  logic addr_hit;
  logic byte_take;
  logic ack_fire;
  logic ack_good;
  logic pay_fire;
  logic pay_to_data;
  logic pend;
  logic is_data;

  assign in_ready  = ~pend;
  assign byte_take = in_valid & in_ready;

  i2cw_addr_check #(.ADDR_LO(ADDR_LO)) u_addr (
    .byte_in (in_byte),
    .match   (addr_hit)
  );

  i2cw_phase_fsm u_fsm (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_evt   (start_evt),
    .stop_evt    (stop_evt),
    .byte_take   (byte_take),
    .byte_in     (in_byte),
    .addr_hit    (addr_hit),
    .ack_fire    (ack_fire),
    .ack_good    (ack_good),
    .pay_fire    (pay_fire),
    .pay_to_data (pay_to_data)
  );

  i2cw_out_slot u_slot (
    .clk          (clk),
    .rst_n        (rst_n),
    .load         (pay_fire),
    .load_byte    (in_byte),
    .load_to_data (pay_to_data),
    .out_ready    (out_ready),
    .pend         (pend),
    .out_byte     (out_byte),
    .is_data      (is_data)
  );

  assign cmd_valid  = pend & ~is_data;
  assign data_valid = pend & is_data;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ack_stb <= 1'b0;
      ack_ok  <= 1'b0;
    end else begin
      ack_stb <= ack_fire;
      ack_ok  <= ack_fire & ack_good;
    end
  end

  assert_ack_after_take_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ack_stb |-> $past(in_valid && in_ready));
  assert_no_take_blocked_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !in_ready) |=> !ack_stb);
  assert_event_discard_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (start_evt || stop_evt) |=> !ack_stb);
  assert_one_target_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({cmd_valid, data_valid}));
endmodule

// File: tb/i2cw_byte_parser_bench.sv
module i2cw_byte_parser_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start_evt = 1'b0;
  logic       stop_evt = 1'b0;
  logic       in_valid = 1'b0;
  logic [7:0] in_byte = 8'h00;
  logic       out_ready = 1'b1;
  logic       in_ready;
  logic [7:0] out_byte;
  logic       cmd_valid;
  logic       data_valid;
  logic       ack_stb;
  logic       ack_ok;

  int checks = 0;
  int fails = 0;
  int cyc = 0;
  int rdy_mode = 0;

  // reference model state
  int  m_ph = 0;       // 0 idle, 1 address, 2 control, 3 payload
  int  m_left = 0;     // payload bytes left: 1 for a pair, -1 for an open stream
  bit  m_sel = 0;
  bit  m_pend = 0;
  bit  m_isdata = 0;
  byte unsigned m_byte = 0;
  bit  m_ack_stb = 0;
  bit  m_ack_ok = 0;

  always #5 clk = ~clk;

  i2cw_byte_parser u_i2cw_byte_parser (
    .clk(clk), .rst_n(rst_n), .start_evt(start_evt), .stop_evt(stop_evt),
    .in_valid(in_valid), .in_ready(in_ready), .in_byte(in_byte),
    .out_byte(out_byte), .cmd_valid(cmd_valid), .data_valid(data_valid),
    .out_ready(out_ready), .ack_stb(ack_stb), .ack_ok(ack_ok)
  );

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_ph = 0; m_left = 0; m_sel = 0; m_pend = 0; m_isdata = 0;
      m_byte = 0; m_ack_stb = 0; m_ack_ok = 0;
    end else begin
      automatic bit acc = in_valid && !m_pend;
      if (m_pend && out_ready) m_pend = 0;
      m_ack_stb = 0;
      m_ack_ok = 0;
      if (start_evt) m_ph = 1;
      else if (stop_evt) m_ph = 0;
      else if (acc && m_ph != 0) begin
        m_ack_stb = 1;
        if (m_ph == 1) begin
          if (in_byte == {5'b01111, 2'b00, 1'b0}) begin m_ack_ok = 1; m_ph = 2; end
          else m_ph = 0;
        end else if (m_ph == 2) begin
          m_ack_ok = 1;
          m_sel = in_byte[6];
          m_left = in_byte[7] ? 1 : -1;
          m_ph = 3;
        end else begin
          m_ack_ok = 1;
          m_pend = 1; m_byte = in_byte; m_isdata = m_sel;
          if (m_left == 1) m_ph = 2;
        end
      end
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at cycle %0d", req, act, exp, cyc);
    end
  endtask

  // per-cycle comparison away from the active edge
  always @(negedge clk) begin
    cyc++;
    if (rst_n) begin
      check(in_ready == !m_pend, "R8 in_ready", in_ready, !m_pend);
      check(cmd_valid == (m_pend && !m_isdata), "R7 cmd_valid (R4/R5/R6 routing)", cmd_valid, m_pend && !m_isdata);
      check(data_valid == (m_pend && m_isdata), "R7 data_valid (R4/R5/R6 routing)", data_valid, m_pend && m_isdata);
      if (m_pend) check(out_byte == m_byte, "R7 out_byte", out_byte, m_byte);
      check(ack_stb == m_ack_stb, "R3 ack_stb (R2/R9 discard)", ack_stb, m_ack_stb);
      if (m_ack_stb) check(ack_ok == m_ack_ok, "R1 ack_ok (R2 nack)", ack_ok, m_ack_ok);
      case (rdy_mode)
        0: out_ready <= 1'b1;
        1: out_ready <= cyc[0];
        default: out_ready <= (cyc % 4 == 0);
      endcase
    end
    if (cyc == 150000) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  task automatic send(input logic [7:0] b);
    @(negedge clk);
    while (!in_ready) @(negedge clk);
    in_valid = 1'b1; in_byte = b;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic pulse(input bit s, input bit p, input bit with_byte, input logic [7:0] b);
    @(negedge clk);
    while (!in_ready) @(negedge clk);
    start_evt = s; stop_evt = p; in_valid = with_byte; in_byte = b;
    @(negedge clk);
    start_evt = 1'b0; stop_evt = 1'b0; in_valid = 1'b0;
  endtask

  task automatic drain();
    repeat (12) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R10: reset values at the ports
    check(in_ready == 1'b1, "R10 in_ready", in_ready, 1);
    check(cmd_valid == 1'b0 && data_valid == 1'b0, "R10 valids", {cmd_valid, data_valid}, 0);
    check(ack_stb == 1'b0, "R10 ack_stb", ack_stb, 0);
    rst_n = 1'b1;

    // R2/R3: bytes before any START are not acknowledged
    send(8'h78); send(8'h40); send(8'h11);
    drain();

    for (int mode = 0; mode < 3; mode++) begin
      rdy_mode = mode;
      // R1, R5: pairs then R6 stream with data target
      pulse(1, 0, 0, 8'h00);
      send(8'h78);
      send(8'hC0); send(8'hA5);
      send(8'h80); send(8'h21);
      send(8'h40);
      for (int i = 0; i < 5; i++) send(8'h30 + i[7:0] + mode[7:0]);
      pulse(0, 1, 0, 8'h00);
      drain();
      // R4: low bits set in control bytes, command stream
      pulse(1, 0, 0, 8'h00);
      send(8'h78);
      send(8'hFF); send(8'h5A);
      send(8'h3F);
      for (int i = 0; i < 4; i++) send(8'hE0 + i[7:0]);
      // R9: repeated START mid-stream, byte in same cycle discarded
      pulse(1, 0, 1, 8'h99);
      send(8'h78);
      send(8'h7F); send(8'h12); send(8'h34);
      // R9: STOP with a byte in the same cycle, then more bytes ignored
      pulse(0, 1, 1, 8'h56);
      send(8'h77);
      drain();
      // R2: wrong address, then ignored bytes
      pulse(1, 0, 0, 8'h00);
      send(8'h7A); send(8'h40); send(8'h01);
      // R2: read bit set
      pulse(1, 0, 0, 8'h00);
      send(8'h79); send(8'hC0); send(8'h02);
      // R9: START and STOP together, START wins
      pulse(1, 1, 0, 8'h00);
      send(8'h78); send(8'h00); send(8'h03);
      pulse(0, 1, 0, 8'h00);
      drain();
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule